// File: doc/BRIEF.md
# Command Slot Dispatch Pipeline

This block moves command slot numbers through two chained stages. A slot number is a 5-bit token. The host pushes a token either for an indirect command or for a direct command.

For an indirect command, the token enters a fetch queue. The fetch sequencer takes the token at the head of that queue and issues one request for the slot's request block. It then accepts 8 qwords from the host-side response stream and writes them into the slot's window of the local dual-port RAM. Only after the last write does it hand the token to the execute queue.

For a direct command, the host has already placed the block in RAM itself. The token therefore goes straight into the execute queue.

The execute sequencer takes one token at a time and starts the downstream link with that slot number. It waits for the link's done signal, then reports the finished slot with a one-cycle completion pulse.

A second RAM port gives read access to the stored blocks. The choice of free slots is left entirely to the host.

The two streams follow valid/ready rules:
- A request transfers on a cycle where `req_valid` and `req_ready` are both high. Once raised, `req_valid` and `req_slot` hold until that cycle.
- A response beat transfers on a cycle where `rsp_valid` and `rsp_ready` are both high. The responder may stall at will by holding `rsp_valid` low.
- The sequencer raises `rsp_ready` only while it is collecting a block.

Pushes are plain strobes with no back-pressure. A push that cannot be taken is dropped and reported on an error pin.

Top module: `slot_dispatch`

## Requirements
- R1: After reset, both queues are empty and both sequencers are idle. `req_valid`, `rsp_ready`, `exec_start`, `cpl_valid`, `err_bad_slot` and `err_full` are all low.
- R2: Valid slot values are 0 to 30. A push with `cmd_slot` = 31 is dropped in either mode, so no request and no start follow from it. `err_bad_slot` is high for exactly the cycle after that push.
- R3: Each queue holds 31 tokens. A push aimed at a full queue is dropped, and `err_full` is high for the cycle after it. Tokens already queued are unaffected.
- R4: An indirect push (`cmd_direct` = 0) leads to one request carrying that slot. Requests are issued in push order.
- R5: Beat k (0 to 7) of a fetched block is written, in ascending order, to RAM qword address slot×16+k.
- R6: Writes from the fetch path never touch qword addresses 496 to 511. They also never touch offsets 8 to 15 inside a slot window.
- R7: An indirect token enters the execute queue only after the 8th beat has been written. Indirect commands complete in the order they were pushed.
- R8: A direct push (`cmd_direct` = 1) bypasses fetching. It issues no request, and direct commands complete in push order.
- R9: `exec_start` rises with `exec_slot` and holds both steady until a cycle with `exec_done` high. Only one slot is started at a time.
- R10: `cpl_valid` is high for the single cycle after the cycle in which `exec_done` was accepted. In that cycle `cpl_slot` equals the finished slot.
- R11: `exec_done` is ignored while `exec_start` is low, so no completion pulse appears.
- R12: A direct push and a fetch hand-off can aim at the execute queue in the same cycle. The direct token then enters first, and the hand-off follows one cycle later. Neither token is lost.
- R13: The RAM read port returns the qword at `ram_rd_addr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_push | input | 1 | Push strobe for one slot token |
| cmd_direct | input | 1 | 1 = block already in RAM, 0 = fetch it |
| cmd_slot | input | 5 | Slot token being pushed |
| err_bad_slot | output | 1 | Pulse: pushed slot value 31 was dropped |
| err_full | output | 1 | Pulse: push dropped because target queue was full |
| req_valid | output | 1 | Fetch request valid |
| req_ready | input | 1 | Fetch request accepted |
| req_slot | output | 5 | Slot whose block is requested |
| rsp_valid | input | 1 | Response qword valid |
| rsp_ready | output | 1 | Sequencer can take a response qword |
| rsp_data | input | 64 | Response qword |
| ram_rd_addr | input | 9 | RAM read port qword address |
| ram_rd_data | output | 64 | RAM read data, one cycle latency |
| exec_start | output | 1 | Link start, held until done |
| exec_slot | output | 5 | Slot being executed |
| exec_done | input | 1 | Link finished the started slot |
| cpl_valid | output | 1 | One-cycle completion pulse |
| cpl_slot | output | 5 | Slot that completed |

## Verification
The interesting collision is a direct push landing in the same cycle that the fetch sequencer offers its finished token to the execute queue. Both then compete for the one write port of that queue.

The bench provokes this collision in a directed way:
- It holds the response stream always valid and counts eight beats from the first cycle `rsp_ready` is seen high.
- It times a direct push to the next cycle and holds the link busy.
- It then judges the outcome from the completion order at the ports: the direct slot must finish before the fetched slot, and both must finish.

Random traffic then mixes both push kinds, with stalls on both streams, so that the collision also occurs at unplanned moments. Per-path completion order and the final RAM image are checked afterwards.

// File: rtl/sd_pkg.sv
package sd_pkg;
  typedef enum logic [1:0] {F_IDLE, F_REQ, F_DATA, F_HAND} fetch_st_e;
  typedef enum logic [0:0] {X_IDLE, X_RUN} exec_st_e;
endpackage

// File: rtl/sd_slot_fifo.sv
module sd_slot_fifo #(
  parameter int W     = 5,
  parameter int DEPTH = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= step(wptr);
      if (do_pop)  rptr <= step(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sd_fetch_seq.sv
module sd_fetch_seq
  import sd_pkg::*;
#(
  parameter int SLOT_W      = 5,
  parameter int DATA_W      = 64,
  parameter int RAM_AW      = 9,
  parameter int QW_PER_SLOT = 16,
  parameter int REQ_QW      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_empty,
  input  logic [SLOT_W-1:0] q_head,
  output logic              q_pop,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [SLOT_W-1:0] req_slot,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              wr_en,
  output logic [RAM_AW-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              hand_valid,
  output logic [SLOT_W-1:0] hand_slot,
  input  logic              hand_take
);
  localparam int BW = (REQ_QW > 1) ? $clog2(REQ_QW) : 1;
  localparam logic [BW-1:0] LAST_BEAT = BW'(REQ_QW - 1);

  fetch_st_e         st;
  logic [SLOT_W-1:0] slot_q;
  logic [BW-1:0]     beat;

  assign q_pop      = (st == F_IDLE) && !q_empty;
  assign req_valid  = (st == F_REQ);
  assign req_slot   = slot_q;
  assign rsp_ready  = (st == F_DATA);
  assign wr_en      = rsp_valid && rsp_ready;
  assign wr_addr    = RAM_AW'(slot_q) * RAM_AW'(QW_PER_SLOT) + RAM_AW'(beat);
  assign wr_data    = rsp_data;
  assign hand_valid = (st == F_HAND);
  assign hand_slot  = slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= F_IDLE;
      slot_q <= '0;
      beat   <= '0;
    end else begin
      case (st)
        F_IDLE: if (!q_empty) begin
          slot_q <= q_head;
          st     <= F_REQ;
        end
        F_REQ: if (req_ready) begin
          beat <= '0;
          st   <= F_DATA;
        end
        F_DATA: if (wr_en) begin
          beat <= beat + 1'b1;
          if (beat == LAST_BEAT) st <= F_HAND;
        end
        F_HAND: if (hand_take) st <= F_IDLE;
        default: st <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_exec_seq.sv
module sd_exec_seq
  import sd_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_empty,
  input  logic [SLOT_W-1:0] q_head,
  output logic              q_pop,
  output logic              exec_start,
  output logic [SLOT_W-1:0] exec_slot,
  input  logic              exec_done,
  output logic              cpl_valid,
  output logic [SLOT_W-1:0] cpl_slot
);
  exec_st_e          st;
  logic [SLOT_W-1:0] slot_q;

  assign q_pop      = (st == X_IDLE) && !q_empty;
  assign exec_start = (st == X_RUN);
  assign exec_slot  = slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= X_IDLE;
      slot_q    <= '0;
      cpl_valid <= 1'b0;
      cpl_slot  <= '0;
    end else begin
      cpl_valid <= 1'b0;
      case (st)
        X_IDLE: if (!q_empty) begin
          slot_q <= q_head;
          st     <= X_RUN;
        end
        X_RUN: if (exec_done) begin
          cpl_valid <= 1'b1;
          cpl_slot  <= slot_q;
          st        <= X_IDLE;
        end
        default: st <= X_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_local_ram.sv
module sd_local_ram #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 512,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/slot_dispatch.sv
module slot_dispatch #(
  parameter int SLOT_W      = 5,
  parameter int QDEPTH      = 31,
  parameter int QW_PER_SLOT = 16,
  parameter int REQ_QW      = 8,
  parameter int DATA_W      = 64,
  parameter int RAM_DEPTH   = 512,
  localparam int RAM_AW     = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_push,
  input  logic              cmd_direct,
  input  logic [SLOT_W-1:0] cmd_slot,
  output logic              err_bad_slot,
  output logic              err_full,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [SLOT_W-1:0] req_slot,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic [RAM_AW-1:0] ram_rd_addr,
  output logic [DATA_W-1:0] ram_rd_data,
  output logic              exec_start,
  output logic [SLOT_W-1:0] exec_slot,
  input  logic              exec_done,
  output logic              cpl_valid,
  output logic [SLOT_W-1:0] cpl_slot
);
  logic              slot_ok, dir_push, ind_push;
  logic              fq_push, fq_pop, fq_empty, fq_full;
  logic [SLOT_W-1:0] fq_head;
  logic              xq_push, xq_pop, xq_empty, xq_full;
  logic [SLOT_W-1:0] xq_head, xq_data;
  logic              ram_we;
  logic [RAM_AW-1:0] ram_waddr;
  logic [DATA_W-1:0] ram_wdata;
  logic              hand_valid, hand_take;
  logic [SLOT_W-1:0] hand_slot;

  // token admission and execute-queue arbitration (direct push wins)
  assign slot_ok   = 32'(cmd_slot) < QDEPTH;
  assign dir_push  = cmd_push && slot_ok && cmd_direct;
  assign ind_push  = cmd_push && slot_ok && !cmd_direct;
  assign fq_push   = ind_push && !fq_full;
  assign hand_take = hand_valid && !dir_push && !xq_full;
  assign xq_push   = (dir_push && !xq_full) || hand_take;
  assign xq_data   = dir_push ? cmd_slot : hand_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_bad_slot <= 1'b0;
      err_full     <= 1'b0;
    end else begin
      err_bad_slot <= cmd_push && !slot_ok;
      err_full     <= (ind_push && fq_full) || (dir_push && xq_full);
    end
  end

  sd_slot_fifo #(.W(SLOT_W), .DEPTH(QDEPTH)) u_fetch_q (
    .clk, .rst_n, .push(fq_push), .push_data(cmd_slot), .pop(fq_pop),
    .head(fq_head), .empty(fq_empty), .full(fq_full)
  );

  sd_slot_fifo #(.W(SLOT_W), .DEPTH(QDEPTH)) u_exec_q (
    .clk, .rst_n, .push(xq_push), .push_data(xq_data), .pop(xq_pop),
    .head(xq_head), .empty(xq_empty), .full(xq_full)
  );

  sd_fetch_seq #(
    .SLOT_W(SLOT_W), .DATA_W(DATA_W), .RAM_AW(RAM_AW),
    .QW_PER_SLOT(QW_PER_SLOT), .REQ_QW(REQ_QW)
  ) u_fetch (
    .clk, .rst_n, .q_empty(fq_empty), .q_head(fq_head), .q_pop(fq_pop),
    .req_valid, .req_ready, .req_slot, .rsp_valid, .rsp_ready, .rsp_data,
    .wr_en(ram_we), .wr_addr(ram_waddr), .wr_data(ram_wdata),
    .hand_valid, .hand_slot, .hand_take
  );

  sd_exec_seq #(.SLOT_W(SLOT_W)) u_exec (
    .clk, .rst_n, .q_empty(xq_empty), .q_head(xq_head), .q_pop(xq_pop),
    .exec_start, .exec_slot, .exec_done, .cpl_valid, .cpl_slot
  );

  sd_local_ram #(.DATA_W(DATA_W), .DEPTH(RAM_DEPTH)) u_ram (
    .clk, .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_rd_addr), .rdata(ram_rd_data)
  );
endmodule

// File: rtl/slot_dispatch_chk.sv
module slot_dispatch_chk #(
  parameter int SLOT_W      = 5,
  parameter int QDEPTH      = 31,
  parameter int QW_PER_SLOT = 16,
  parameter int REQ_QW      = 8,
  parameter int RAM_AW      = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_push,
  input logic [SLOT_W-1:0] cmd_slot,
  input logic              err_bad_slot,
  input logic              req_valid,
  input logic              req_ready,
  input logic [SLOT_W-1:0] req_slot,
  input logic              ram_we,
  input logic [RAM_AW-1:0] ram_waddr,
  input logic              hand_take,
  input logic              exec_start,
  input logic [SLOT_W-1:0] exec_slot,
  input logic              exec_done,
  input logic              cpl_valid,
  input logic [SLOT_W-1:0] cpl_slot
);
  localparam int CW = $clog2(REQ_QW + 1) + 1;
  localparam int RESV_BASE = QDEPTH * QW_PER_SLOT;

  logic [CW-1:0] wcnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                      wcnt <= '0;
    else if (req_valid && req_ready) wcnt <= '0;
    else if (ram_we)                 wcnt <= wcnt + 1'b1;
  end

  // R2
  bad_slot_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_push && 32'(cmd_slot) >= QDEPTH) |=> err_bad_slot);

  // R4
  req_slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> 32'(req_slot) < QDEPTH);

  // R6
  no_reserved_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (32'(ram_waddr) < RESV_BASE) && ((32'(ram_waddr) % QW_PER_SLOT) < REQ_QW));

  // R7
  handoff_after_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hand_take |-> 32'(wcnt) == REQ_QW);

  // R9
  start_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_start && !exec_done) |=> (exec_start && $stable(exec_slot)));

  // R10
  cpl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_start && exec_done) |=> (cpl_valid && cpl_slot == $past(exec_slot)));

  // R11
  idle_done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_start |=> !cpl_valid);
endmodule

bind slot_dispatch slot_dispatch_chk #(
  .SLOT_W(SLOT_W), .QDEPTH(QDEPTH), .QW_PER_SLOT(QW_PER_SLOT),
  .REQ_QW(REQ_QW), .RAM_AW(RAM_AW)
) u_chk (.*);

// File: tb/slot_dispatch_bench.sv
module slot_dispatch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 5;
  localparam int QD = 31;
  localparam int QW = 16;
  localparam int RQ = 8;
  localparam int DW = 64;
  localparam int RD = 512;
  localparam int AW = 9;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          cmd_push = 1'b0, cmd_direct = 1'b0;
  logic [SW-1:0] cmd_slot = '0;
  logic          err_bad_slot, err_full;
  logic          req_valid, rsp_ready;
  logic          req_ready = 1'b0, rsp_valid = 1'b0;
  logic [SW-1:0] req_slot;
  logic [DW-1:0] rsp_data = '0;
  logic [AW-1:0] ram_rd_addr = '0;
  logic [DW-1:0] ram_rd_data;
  logic          exec_start, cpl_valid;
  logic          exec_done = 1'b0;
  logic [SW-1:0] exec_slot, cpl_slot;

  slot_dispatch u_slot_dispatch (
    .clk, .rst_n, .cmd_push, .cmd_direct, .cmd_slot, .err_bad_slot, .err_full,
    .req_valid, .req_ready, .req_slot, .rsp_valid, .rsp_ready, .rsp_data,
    .ram_rd_addr, .ram_rd_data, .exec_start, .exec_slot, .exec_done,
    .cpl_valid, .cpl_slot
  );

  int checks = 0, fails = 0;
  int dq[$], iq[$], rq[$], cpl_log[$];
  logic [DW-1:0] exp_ram [RD];
  bit host_rnd = 1'b1, link_hold = 1'b0, force_done = 1'b0, mon_en = 1'b0;
  int cur_slot = 0, beat = 0, seqn = 0, wait_cnt = 0, pend_slot = 0;
  bit pend_cpl = 1'b0, prev_start = 1'b0, prev_done = 1'b0;
  logic [SW-1:0] prev_slot = '0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      check(1'b0, "watchdog", "run did not end", DW'(cyc), DW'(WATCHDOG));
      summary();
    end
  end

  // link, host and completion models: all driven and sampled at negedge
  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      if (pend_cpl) begin
        // R10
        check(cpl_valid === 1'b1 && int'(cpl_slot) == pend_slot, "R10",
              "completion pulse slot", DW'(cpl_slot), DW'(pend_slot));
        cpl_log.push_back(pend_slot);
        if (dq.size() > 0 && dq[0] == pend_slot) void'(dq.pop_front());
        else if (iq.size() > 0 && iq[0] == pend_slot) void'(iq.pop_front());
        else check(1'b0, "R7 R8", "completion out of path order", DW'(pend_slot), '1);
        pend_cpl = 1'b0;
      end else if (cpl_valid) begin
        check(1'b0, "R11", "unexpected completion", DW'(cpl_slot), '0);
      end
      if (prev_start && !prev_done)
        check(exec_start && exec_slot == prev_slot, "R9", "start held with slot",
              DW'({exec_start, exec_slot}), DW'({1'b1, prev_slot}));
      exec_done = force_done;
      if (exec_start && !link_hold) begin
        if (wait_cnt == 0) begin
          exec_done = 1'b1;
          pend_cpl  = 1'b1;
          pend_slot = int'(exec_slot);
          wait_cnt  = $urandom_range(0, 3);
        end else wait_cnt--;
      end
      prev_start = exec_start;
      prev_slot  = exec_slot;
      prev_done  = exec_done;
      req_ready = host_rnd ? 1'($urandom_range(0, 1)) : 1'b1;
      if (req_valid && req_ready) begin
        // R4 and R8: requests only for indirect slots, in push order
        check(rq.size() > 0 && rq[0] == int'(req_slot), "R4 R8", "request slot",
              DW'(req_slot), DW'(rq.size() > 0 ? rq[0] : -1));
        if (rq.size() > 0) void'(rq.pop_front());
        cur_slot = int'(req_slot);
        beat = 0;
      end
      rsp_valid = host_rnd ? ($urandom_range(0, 2) != 0) : 1'b1;
      rsp_data  = {16'(seqn), 8'(cur_slot), 8'(beat), 32'($urandom)};
      if (rsp_valid && rsp_ready) begin
        exp_ram[cur_slot * QW + beat] = rsp_data;
        beat++;
        seqn++;
      end
    end
  end

  task automatic push(input int slot, input bit direct, input bit exp_bad, input bit exp_full);
    cmd_push = 1'b1;
    cmd_direct = direct;
    cmd_slot = SW'(slot);
    if (!exp_bad && !exp_full) begin
      if (direct) dq.push_back(slot);
      else begin
        iq.push_back(slot);
        rq.push_back(slot);
      end
    end
    @(negedge clk);
    cmd_push = 1'b0;
    check(err_bad_slot == exp_bad, "R2", "bad slot flag", DW'(err_bad_slot), DW'(exp_bad));
    check(err_full == exp_full, "R3", "full flag", DW'(err_full), DW'(exp_full));
  endtask

  task automatic read_ram(input int a, output logic [DW-1:0] d);
    ram_rd_addr = AW'(a);
    @(negedge clk);
    d = ram_rd_data;
  endtask

  task automatic wait_idle(input string tag);
    int t = 0;
    while ((dq.size() > 0 || iq.size() > 0 || pend_cpl) && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    check(t < 5000, tag, "all pushed slots completed", DW'(dq.size() + iq.size()), '0);
  endtask

  initial begin
    logic [DW-1:0] d;
    int n0;
    void'($urandom(32'd7331));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check({err_bad_slot, err_full, req_valid, rsp_ready, exec_start, cpl_valid} == 6'b0,
          "R1", "outputs after reset",
          DW'({err_bad_slot, err_full, req_valid, rsp_ready, exec_start, cpl_valid}), '0);
    // R13: snapshot the initial RAM image through the read port
    for (int a = 0; a < RD; a++) begin
      read_ram(a, d);
      exp_ram[a] = d;
    end
    mon_en = 1'b1;

    // R2: value 31 dropped in both modes
    push(31, 1'b1, 1'b1, 1'b0);
    push(31, 1'b0, 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    check(!exec_start && !req_valid, "R2", "dropped slot started nothing",
          DW'({exec_start, req_valid}), '0);

    // R11: done while idle
    force_done = 1'b1;
    repeat (5) @(negedge clk);
    force_done = 1'b0;
    @(negedge clk);
    check(!cpl_valid, "R11", "no pulse from idle done", DW'(cpl_valid), '0);

    // R8: direct bypass order
    push(3, 1'b1, 1'b0, 1'b0);
    push(7, 1'b1, 1'b0, 1'b0);
    wait_idle("R8");
    check(cpl_log.size() >= 2 && cpl_log[cpl_log.size()-2] == 3 && cpl_log[cpl_log.size()-1] == 7,
          "R8", "direct completion order", DW'(cpl_log.size()), 64'd2);

    // R4 R5 R7: indirect fetch
    push(20, 1'b0, 1'b0, 1'b0);
    push(21, 1'b0, 1'b0, 1'b0);
    wait_idle("R7");
    check(cpl_log[cpl_log.size()-2] == 20 && cpl_log[cpl_log.size()-1] == 21,
          "R7", "indirect completion order", DW'(cpl_log[cpl_log.size()-1]), 64'd21);

    // R12: direct push in the hand-off cycle
    host_rnd  = 1'b0;
    link_hold = 1'b1;
    push(25, 1'b0, 1'b0, 1'b0);
    while (!rsp_ready) @(negedge clk);
    repeat (RQ) @(negedge clk);
    push(9, 1'b1, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    n0 = cpl_log.size();
    link_hold = 1'b0;
    wait_idle("R12");
    check(cpl_log.size() == n0 + 2 && cpl_log[n0] == 9 && cpl_log[n0+1] == 25,
          "R12", "direct token ahead of hand-off", DW'(cpl_log[n0]), 64'd9);
    host_rnd = 1'b1;

    // R3: fill the execute queue while the link is held
    link_hold = 1'b1;
    n0 = cpl_log.size();
    for (int i = 0; i < QD + 1; i++) push(i % 15, 1'b1, 1'b0, 1'b0);
    push(14, 1'b1, 1'b0, 1'b1);
    link_hold = 1'b0;
    wait_idle("R3");
    check(cpl_log.size() == n0 + QD + 1, "R3", "only accepted tokens completed",
          DW'(cpl_log.size() - n0), DW'(QD + 1));

    // random mix of both modes with stalls on both streams
    for (int it = 0; it < 600; it++) begin
      if (dq.size() + iq.size() < 20 && $urandom_range(0, 2) == 0) begin
        if ($urandom_range(0, 19) == 0) push(31, 1'($urandom_range(0, 1)), 1'b1, 1'b0);
        else if ($urandom_range(0, 1) == 0) push($urandom_range(0, 14), 1'b1, 1'b0, 1'b0);
        else push($urandom_range(15, 30), 1'b0, 1'b0, 1'b0);
      end else @(negedge clk);
    end
    wait_idle("R7 R8");

    // R5 R6 R13: final RAM image
    for (int a = 0; a < RD; a++) begin
      read_ram(a, d);
      if (a >= QD * QW || (a % QW) >= RQ)
        check(d == exp_ram[a], "R6", $sformatf("untouched qword %0d", a), d, exp_ram[a]);
      else
        check(d == exp_ram[a], "R5", $sformatf("fetched qword %0d", a), d, exp_ram[a]);
    end
    summary();
  end
endmodule